// File: doc/BRIEF.md
# Retrace Status Generator

This block runs the horizontal and vertical scan position of a display controller from a dot-clock enable and presents the blanking state as a readable status byte. A dot counter marks the end of each character cell, which is 8 or 9 dots wide; a character counter walks across the line; and a line counter advances once per line. The character position is compared against a 5-bit horizontal blanking window and the line position against a 7-bit vertical blanking window. A blanking end value that is numerically below its start wraps, and is treated as lying one field-width above it.

Each of the two retrace indications can be inverted by its own polarity input before it reaches the status byte. Bit 0 of the status byte reports that either indication is asserted, and bit 3 reports the vertical indication alone. A status read strobe produces a one-cycle pulse that returns the attribute controller's address/data flip-flop to its address state.

Top module: `retrace_status`

## Requirements
- R1: A character cell is 9 dot enables long when `dots9` is 1 and 8 dot enables long when it is 0. The character counter advances on the dot enable that completes a cell.
- R2: The character counter counts 0 to `htotal` + 4 and then returns to 0. A line is therefore `htotal` + 5 characters long.
- R3: The line counter advances once, on the dot enable that completes the last character of a line. It returns to 0 when the incremented value would reach `vtotal`. When `vtotal` is 0 or 1, it stays at 0.
- R4: Horizontal blanking is active when the character position lies in [`hbl_start`, E). E equals `hbl_end`, plus 32 when `hbl_end` < `hbl_start`. Equal start and end values give no blanking.
- R5: Vertical blanking is active when the line position lies in [`vbl_start`, E). E equals `vbl_end`, plus 128 when `vbl_end` < `vbl_start`.
- R6: The horizontal indication is inverted when `hsync_inv` is 1, and the vertical indication is inverted when `vsync_inv` is 1.
- R7: `status[0]` is the OR of the two indications and `status[3]` is the vertical indication. Bits 1, 2 and 7:4 always read 0.
- R8: `ac_ff_clr` is 1 in exactly the cycle that follows each cycle in which `status_rd` is 1.
- R9: While `rst_n` is low, all counters are held at 0 and `ac_ff_clr` is 0.
- R10: While `dot_en` is low, no counter changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dot_en | input | 1 | One pulse per dot |
| dots9 | input | 1 | 1: 9-dot characters, 0: 8-dot |
| htotal | input | HT_W | Line length minus 5, in characters |
| vtotal | input | VT_W | Lines per frame |
| hbl_start | input | 5 | Horizontal blanking start, in characters |
| hbl_end | input | 5 | Horizontal blanking end, partial field |
| vbl_start | input | 7 | Vertical blanking start, in lines |
| vbl_end | input | 7 | Vertical blanking end, partial field |
| hsync_inv | input | 1 | Invert the horizontal indication |
| vsync_inv | input | 1 | Invert the vertical indication |
| status_rd | input | 1 | Status register read strobe |
| status | output | 8 | Input status byte |
| ac_ff_clr | output | 1 | Flip-flop reset pulse |

## Verification
The assertions check five properties on every cycle:
- the reserved status bits stay at zero;
- the vertical bit never appears without bit 0 when polarity is normal;
- the clear pulse tracks the read strobe by exactly one cycle;
- the counters freeze without a dot enable;
- the line counter moves only as the character counter returns to zero.

The bench's reference model and its scenarios are needed to show the rest: the exact cell width, the line length, the wrapped blanking windows, the frame wrap at small and zero totals, and the effect of polarity inversion on the status byte.

// File: rtl/retrace_status.sv
module retrace_status #(
  parameter int HT_W = 8,
  parameter int VT_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dot_en,
  input  logic            dots9,
  input  logic [HT_W-1:0] htotal,
  input  logic [VT_W-1:0] vtotal,
  input  logic [4:0]      hbl_start,
  input  logic [4:0]      hbl_end,
  input  logic [6:0]      vbl_start,
  input  logic [6:0]      vbl_end,
  input  logic            hsync_inv,
  input  logic            vsync_inv,
  input  logic            status_rd,
  output logic [7:0]      status,
  output logic            ac_ff_clr
);
  localparam int CH_W = HT_W + 1;

  logic [3:0]      dot_q;
  logic [CH_W-1:0] char_q;
  logic [VT_W-1:0] line_q;

  wire [3:0]      dot_last   = dots9 ? 4'd8 : 4'd7;
  wire            cell_done  = dot_en && (dot_q >= dot_last);
  wire [CH_W:0]   line_chars = (CH_W+1)'(htotal) + (CH_W+1)'(5);
  wire            line_done  = cell_done && ((CH_W+1)'(char_q) + 1'b1 >= line_chars);
  wire            frame_done = line_done && ((VT_W+1)'(line_q) + 1'b1 >= (VT_W+1)'(vtotal));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dot_q  <= '0;
      char_q <= '0;
      line_q <= '0;
    end else if (dot_en) begin
      dot_q <= cell_done ? 4'd0 : dot_q + 4'd1;
      if (cell_done) char_q <= line_done ? '0 : char_q + 1'b1;
      if (line_done) line_q <= frame_done ? '0 : line_q + 1'b1;
    end
  end

  wire [5:0] h_end_x = {hbl_end < hbl_start, hbl_end};
  wire [7:0] v_end_x = {vbl_end < vbl_start, vbl_end};

  wire h_blank = (char_q >= CH_W'(hbl_start)) && (char_q < CH_W'(h_end_x));
  wire v_blank = (line_q >= VT_W'(vbl_start)) && (line_q < VT_W'(v_end_x));

  wire h_ind = h_blank ^ hsync_inv;
  wire v_ind = v_blank ^ vsync_inv;

  assign status = {4'b0000, v_ind, 2'b00, h_ind | v_ind};

  always_ff @(posedge clk) begin
    if (!rst_n) ac_ff_clr <= 1'b0;
    else        ac_ff_clr <= status_rd;
  end
endmodule

// File: rtl/retrace_status_chk.sv
module retrace_status_chk #(
  parameter int CH_W = 9,
  parameter int VT_W = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic            dot_en,
  input logic            status_rd,
  input logic            hsync_inv,
  input logic            vsync_inv,
  input logic [7:0]      status,
  input logic            ac_ff_clr,
  input logic [3:0]      dot_q,
  input logic [CH_W-1:0] char_q,
  input logic [VT_W-1:0] line_q
);
  a_r7_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (status[7:4] == 4'b0) && (status[2:1] == 2'b0));

  a_r7_vert_in_any: assert property (@(posedge clk) disable iff (!rst_n)
    (!hsync_inv && !vsync_inv && status[3]) |-> status[0]);

  a_r8_clear_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    status_rd |=> ac_ff_clr);

  a_r8_no_spurious_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !status_rd |=> !ac_ff_clr);

  a_r10_hold_without_dot: assert property (@(posedge clk) disable iff (!rst_n)
    !dot_en |=> ($stable(dot_q) && $stable(char_q) && $stable(line_q)));

  a_r3_line_moves_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(line_q) |-> (char_q == '0));
endmodule

bind retrace_status retrace_status_chk #(.CH_W(HT_W + 1), .VT_W(VT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .dot_en(dot_en), .status_rd(status_rd),
  .hsync_inv(hsync_inv), .vsync_inv(vsync_inv), .status(status),
  .ac_ff_clr(ac_ff_clr), .dot_q(dot_q), .char_q(char_q), .line_q(line_q)
);

// File: tb/retrace_status_tb.sv
`timescale 1ns/1ps
module retrace_status_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dot_en = 1'b0, dots9 = 1'b0;
  logic [7:0] htotal = 8'd3;
  logic [9:0] vtotal = 10'd12;
  logic [4:0] hbl_start = 5'd0, hbl_end = 5'd0;
  logic [6:0] vbl_start = 7'd0, vbl_end = 7'd0;
  logic       hsync_inv = 1'b0, vsync_inv = 1'b0, status_rd = 1'b0;
  logic [7:0] status;
  logic       ac_ff_clr;

  always #2 clk = ~clk;

  retrace_status dut_i (.*);

  int checks = 0, errors = 0, cycles = 0;
  string req = "R9";
  bit done = 0;
  int m_dot = 0, m_ch = 0, m_ln = 0;
  bit m_clr = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // reference model: scan position and pulse, updated at each edge
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_dot = 0; m_ch = 0; m_ln = 0; m_clr = 0;
    end else begin
      m_clr = status_rd;
      if (dot_en) begin
        m_dot++;
        if (m_dot == (dots9 ? 9 : 8) || m_dot > 9) begin
          m_dot = 0;
          m_ch++;
          if (m_ch >= int'(htotal) + 5) begin
            m_ch = 0;
            m_ln++;
            if (m_ln >= int'(vtotal)) m_ln = 0;
          end
        end
      end
    end
    if (cycles > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      finish_run();
    end
  end

  function automatic bit in_window(input int pos, input int s, input int e, input int wrap);
    int span;
    span = (e < s) ? e + wrap - s : e - s;
    return (pos >= s) && (pos - s < span);
  endfunction

  always @(negedge clk) begin
    bit hx, vx;
    int exp_b0;
    hx = in_window(m_ch, hbl_start, hbl_end, 32) != hsync_inv;
    vx = in_window(m_ln, vbl_start, vbl_end, 128) != vsync_inv;
    exp_b0 = (hx || vx) ? 1 : 0;
    if (rst_n) begin
      check(status[0] == exp_b0, {req, " R4 R7 bit0"}, status[0], exp_b0);
      check(status[3] == vx, {req, " R5 R7 bit3"}, status[3], vx);
      check({status[7:4], status[2:1]} == 6'b0, "R7 reserved", status, 0);
    end
    check(ac_ff_clr == m_clr, {req, " R8 clear"}, ac_ff_clr, m_clr);
  end

  task automatic run(input int n, input int dot_pct, input int rd_pct);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      dot_en = ($urandom_range(99) < dot_pct);
      status_rd = ($urandom_range(99) < rd_pct);
    end
  endtask

  initial begin
    // R9: reset holds clear low and the counters at zero
    repeat (3) @(posedge clk);
    #1;
    check(ac_ff_clr == 1'b0, "R9 reset clear", ac_ff_clr, 0);
    rst_n = 1'b1;
    hbl_start = 5'd2; hbl_end = 5'd5; vbl_start = 7'd3; vbl_end = 7'd6;
    @(negedge clk);
    check(status == 8'h00, "R9 reset status", status, 0);

    req = "R1 R2";  // 8-dot cells, every dot enabled
    run(1200, 100, 10);
    req = "R1 R5";  // 9-dot cells, wrapped windows, sparse dot enables
    dots9 = 1'b1;
    hbl_start = 5'd6; hbl_end = 5'd1; vbl_start = 7'd10; vbl_end = 7'd2;
    run(2500, 50, 20);
    req = "R6";     // both polarities inverted, empty horizontal window
    hsync_inv = 1'b1; vsync_inv = 1'b1; hbl_start = 5'd4; hbl_end = 5'd4;
    vbl_start = 7'd1; vbl_end = 7'd4;
    run(1500, 80, 30);
    hsync_inv = 1'b0;
    run(800, 80, 5);
    req = "R10";    // no dot enables: position frozen
    run(60, 0, 50);
    req = "R3";     // zero line total, long line with wrapped window
    vsync_inv = 1'b0; vtotal = 10'd0; htotal = 8'd20;
    hbl_start = 5'd20; hbl_end = 5'd4; vbl_start = 7'd0; vbl_end = 7'd1;
    run(1500, 90, 10);
    req = "R3 R5";  // small frame with the blanking window at the end
    vtotal = 10'd5; htotal = 8'd0; vbl_start = 7'd3; vbl_end = 7'd5;
    run(2000, 100, 10);
    @(negedge clk);
    finish_run();
  end
endmodule